// File: doc/BRIEF.md
# In-Order Transmit Slot Sequencer

This block sits between a host frame stream and a bank of transmit mailboxes (four with the default parameters). It accepts one frame at a time over a valid/ready handshake. Each frame goes to a mailbox and a transmit priority taken from a single sequence counter: the low bits pick the mailbox and the bits above them pick the priority. The transmitter serves lower priority values first, and the lowest-numbered mailbox first among equal priorities. Because of that rule, frames leave the bus in the order they arrived, even though several mailboxes are armed at once.

Loading a mailbox is a fixed six-beat command burst on the command port. The block also drives the per-mailbox completion interrupt enables. A second counter follows the oldest outstanding frame. Completion and abort events arrive per mailbox and are latched. The block retires mailboxes strictly in load order, and for each frame that was truly sent it raises an acknowledgement strobe that carries the mailbox number.

The input is held off in three cases: all mailboxes are in flight, the next mailbox reports not ready, or the sequence counter has wrapped past its highest priority. In the wrap case, every earlier frame must drain before the lowest priority value can be used again.

Top module: `tx_order_seq`

## Requirements
- R1: After reset both counters are zero, `cmd_valid`, `ack_valid` and every `irq_en` bit are low, and `in_ready` is high when `mb_ready[0]` is high.
- R2: The k-th frame accepted since reset (k counted from 0, modulo 64) is loaded into mailbox k mod 4 with priority (k / 4) mod 16.
- R3: An accepted frame produces `cmd_valid` on six consecutive cycles, starting the cycle after acceptance, with `in_ready` low throughout. The `cmd_op` values and `cmd_data` words, in order, are:
  - 0 (disable): data 0.
  - 1 (identifier): for an extended frame, bit 29 set and bits 28:0 = `in_id`; for a standard frame, bits 28:18 = `in_id[10:0]`.
  - 2 (mode): bits 3:0 = priority, bit 8 set.
  - 3 (data): `in_data[31:0]`.
  - 4 (data): `in_data[63:32]`.
  - 5 (control): bits 3:0 = `in_dlc`, bit 4 = `in_rtr`, bit 7 set.
- R4: While four frames are outstanding, `in_ready` is low.
- R5: While the `mb_ready` bit of the next mailbox is low, `in_ready` is low.
- R6: Once the sequence counter has wrapped to zero, `in_ready` stays low until every outstanding frame has been retired, even when fewer than four are outstanding.
- R7: Retirement happens only at the oldest outstanding mailbox. A completion on a younger mailbox waits, and the younger mailbox is retired in load order (at most one per cycle) once the mailboxes before it have been retired.
- R8: Retiring a completed mailbox raises `ack_valid` for one cycle, with `ack_slot` equal to that mailbox number. Acknowledgements appear in load order.
- R9: A mailbox that reports an abort is retired without an acknowledgement, and its slot becomes free for a new frame.
- R10: A mailbox whose `mb_ready` bit is low when it is retired produces no acknowledgement.
- R11: A mailbox's `irq_en` bit rises when a frame is accepted into it and falls when that mailbox is retired.
- R12: Completion or abort pulses on a mailbox whose `irq_en` bit is low are ignored. They cause no acknowledgement, and they are not remembered for a later frame in that mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host frame present |
| in_ready | output | 1 | Frame accepted on this cycle if valid |
| in_id | input | ID_W (29) | Frame identifier |
| in_ext | input | 1 | Extended identifier format |
| in_rtr | input | 1 | Remote request frame |
| in_dlc | input | DLC_W (4) | Data length code |
| in_data | input | DATA_W (64) | Payload, low word first |
| mb_ready | input | 4 | Per-mailbox ready flag |
| mb_done | input | 4 | Per-mailbox completion pulse |
| mb_abort | input | 4 | Per-mailbox abort pulse |
| cmd_valid | output | 1 | Mailbox load beat valid |
| cmd_op | output | 3 | Beat kind 0..5 (see R3) |
| cmd_mbox | output | MBOX_BITS (2) | Mailbox being loaded |
| cmd_data | output | 32 | Beat data word |
| irq_en | output | 4 | Per-mailbox completion interrupt enable |
| ack_valid | output | 1 | Frame acknowledged as sent |
| ack_slot | output | MBOX_BITS (2) | Mailbox of acknowledged frame |

## Verification
A wrong internal state shows up at the ports in a few specific ways. If the sequence counter is corrupted, the mailbox or priority in the very next load burst is wrong, so the burst scoreboard catches it within six cycles of acceptance. If the follower counter or the event latches are corrupted, acknowledgements come out of order or with a wrong slot, come out for aborted or stray events, or never come out. Either fault also makes `in_ready` wrong at the full, not-ready and wrap boundaries, which are checked a few cycles after each stimulus settles.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

   typedef enum logic [2:0] {
      OP_DISABLE = 3'd0,
      OP_ID      = 3'd1,
      OP_MODE    = 3'd2,
      OP_DLO     = 3'd3,
      OP_DHI     = 3'd4,
      OP_CTRL    = 3'd5
   } load_op_e;

   localparam int WORD_W       = 32;
   localparam int EXT_ID_W     = 29;
   localparam int STD_ID_W     = 11;
   localparam int ID_EXT_BIT   = 29;
   localparam int STD_ID_LSB   = 18;
   localparam int MODE_TX_BIT  = 8;
   localparam int CTRL_RTR_BIT = 4;
   localparam int CTRL_GO_BIT  = 7;

endpackage

// File: rtl/tx_slot_counters.sv
module tx_slot_counters #(
   parameter int MBOX_BITS = 2,
   parameter int PRIO_BITS = 4,
   localparam int CNT_W = MBOX_BITS + PRIO_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             retire,
   output logic [CNT_W-1:0] next_cnt,
   output logic [CNT_W-1:0] echo_cnt,
   output logic             full,
   output logic             wrap_hold,
   output logic             pending
);

   localparam int MBOX_N = 1 << MBOX_BITS;
   localparam logic [CNT_W-1:0] MBOX_N_C = CNT_W'(MBOX_N);

   if (MBOX_BITS < 1 || PRIO_BITS < 1) begin : g_bad_width
      $error("tx_slot_counters: counter fields must be at least one bit");
   end

   logic [CNT_W-1:0] in_flight;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_cnt <= '0;
         echo_cnt <= '0;
      end else begin
         if (accept) next_cnt <= next_cnt + 1'b1;
         if (retire) echo_cnt <= echo_cnt + 1'b1;
      end
   end

   assign in_flight = next_cnt - echo_cnt;
   assign full      = (in_flight == MBOX_N_C);
   assign pending   = (in_flight != '0);
   assign wrap_hold = (next_cnt == '0) && (echo_cnt != '0);

   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight <= MBOX_N_C);

   p_accept_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !full && !wrap_hold);

   p_retire_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> pending);

   p_echo_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> echo_cnt == $past(echo_cnt) + 1'b1);

endmodule

// File: rtl/tx_load_fsm.sv
module tx_load_fsm
   import tx_seq_pkg::*;
#(
   parameter int MBOX_BITS = 2,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 29,
   parameter int DATA_W    = 64,
   parameter int DLC_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic [ID_W-1:0]      in_id,
   input  logic                 in_ext,
   input  logic                 in_rtr,
   input  logic [DLC_W-1:0]     in_dlc,
   input  logic [DATA_W-1:0]    in_data,
   input  logic [MBOX_BITS-1:0] slot,
   input  logic [PRIO_BITS-1:0] prio,
   output logic                 busy,
   output logic [2:0]           cmd_op,
   output logic [MBOX_BITS-1:0] cmd_mbox,
   output logic [WORD_W-1:0]    cmd_data
);

   if (ID_W != EXT_ID_W) begin : g_bad_id
      $error("tx_load_fsm: identifier width must be 29");
   end
   if (DATA_W != 2 * WORD_W) begin : g_bad_data
      $error("tx_load_fsm: payload must be two words");
   end
   if (DLC_W > CTRL_RTR_BIT || PRIO_BITS > MODE_TX_BIT) begin : g_bad_fields
      $error("tx_load_fsm: length or priority field overlaps a flag bit");
   end

   logic [ID_W-1:0]      f_id;
   logic                 f_ext, f_rtr;
   logic [DLC_W-1:0]     f_dlc;
   logic [DATA_W-1:0]    f_data;
   logic [PRIO_BITS-1:0] f_prio;
   load_op_e             op_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         op_q     <= OP_DISABLE;
         cmd_mbox <= '0;
         f_id     <= '0;
         f_ext    <= 1'b0;
         f_rtr    <= 1'b0;
         f_dlc    <= '0;
         f_data   <= '0;
         f_prio   <= '0;
      end else if (accept) begin
         busy     <= 1'b1;
         op_q     <= OP_DISABLE;
         cmd_mbox <= slot;
         f_id     <= in_id;
         f_ext    <= in_ext;
         f_rtr    <= in_rtr;
         f_dlc    <= in_dlc;
         f_data   <= in_data;
         f_prio   <= prio;
      end else if (busy) begin
         if (op_q == OP_CTRL) busy <= 1'b0;
         else                 op_q <= load_op_e'(op_q + 3'd1);
      end
   end

   always_comb begin
      cmd_data = '0;
      unique case (op_q)
         OP_DISABLE: cmd_data = '0;
         OP_ID: begin
            if (f_ext) begin
               cmd_data[EXT_ID_W-1:0] = f_id;
               cmd_data[ID_EXT_BIT]   = 1'b1;
            end else begin
               cmd_data[STD_ID_LSB +: STD_ID_W] = f_id[STD_ID_W-1:0];
            end
         end
         OP_MODE: begin
            cmd_data[PRIO_BITS-1:0] = f_prio;
            cmd_data[MODE_TX_BIT]   = 1'b1;
         end
         OP_DLO: cmd_data = f_data[WORD_W-1:0];
         OP_DHI: cmd_data = f_data[DATA_W-1:WORD_W];
         OP_CTRL: begin
            cmd_data[DLC_W-1:0]    = f_dlc;
            cmd_data[CTRL_RTR_BIT] = f_rtr;
            cmd_data[CTRL_GO_BIT]  = 1'b1;
         end
         default: cmd_data = '0;
      endcase
   end

   assign cmd_op = op_q;

   p_accept_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !busy);

   p_beat_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (op_q != OP_DISABLE) |-> $past(busy) && (op_q == load_op_e'($past(op_q) + 3'd1)));

   p_burst_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy && (op_q == OP_DISABLE));

endmodule

// File: rtl/tx_retire_unit.sv
module tx_retire_unit #(
   parameter int MBOX_BITS = 2,
   localparam int MBOX_N = 1 << MBOX_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_go,
   input  logic [MBOX_BITS-1:0] load_mb,
   input  logic [MBOX_BITS-1:0] echo_mb,
   input  logic                 pending,
   input  logic [MBOX_N-1:0]    done_pulse,
   input  logic [MBOX_N-1:0]    abort_pulse,
   input  logic [MBOX_N-1:0]    mb_ready,
   output logic                 retire_go,
   output logic [MBOX_N-1:0]    irq_en,
   output logic                 ack_valid,
   output logic [MBOX_BITS-1:0] ack_slot
);

   logic [MBOX_N-1:0] ev_seen;
   logic [MBOX_N-1:0] ev_abort;

   for (genvar i = 0; i < MBOX_N; i++) begin : g_mbox
      logic en_q, ev_q, abt_q;
      logic hit_load, hit_retire;

      assign hit_load   = load_go && (load_mb == MBOX_BITS'(i));
      assign hit_retire = retire_go && (echo_mb == MBOX_BITS'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            ev_q  <= 1'b0;
            abt_q <= 1'b0;
         end else if (hit_load) begin
            en_q  <= 1'b1;
            ev_q  <= 1'b0;
            abt_q <= 1'b0;
         end else if (hit_retire) begin
            en_q  <= 1'b0;
            ev_q  <= 1'b0;
            abt_q <= 1'b0;
         end else if (en_q) begin
            if (done_pulse[i] || abort_pulse[i]) ev_q <= 1'b1;
            if (abort_pulse[i])                  abt_q <= 1'b1;
         end
      end

      assign irq_en[i]   = en_q;
      assign ev_seen[i]  = ev_q;
      assign ev_abort[i] = abt_q;
   end

   assign retire_go = pending && ev_seen[echo_mb];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_slot  <= '0;
      end else begin
         ack_valid <= retire_go && !ev_abort[echo_mb] && mb_ready[echo_mb];
         ack_slot  <= echo_mb;
      end
   end

   p_retire_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      retire_go |-> irq_en[echo_mb]);

   p_load_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load_go |-> !irq_en[load_mb]);

   p_ack_after_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(retire_go));

   p_abort_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retire_go && ev_abort[echo_mb] |=> !ack_valid);

endmodule

// File: rtl/tx_order_seq.sv
module tx_order_seq
   import tx_seq_pkg::*;
#(
   parameter int MBOX_BITS = 2,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 29,
   parameter int DATA_W    = 64,
   parameter int DLC_W     = 4,
   localparam int MBOX_N   = 1 << MBOX_BITS,
   localparam int CNT_W    = MBOX_BITS + PRIO_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [ID_W-1:0]      in_id,
   input  logic                 in_ext,
   input  logic                 in_rtr,
   input  logic [DLC_W-1:0]     in_dlc,
   input  logic [DATA_W-1:0]    in_data,
   input  logic [MBOX_N-1:0]    mb_ready,
   input  logic [MBOX_N-1:0]    mb_done,
   input  logic [MBOX_N-1:0]    mb_abort,
   output logic                 cmd_valid,
   output logic [2:0]           cmd_op,
   output logic [MBOX_BITS-1:0] cmd_mbox,
   output logic [WORD_W-1:0]    cmd_data,
   output logic [MBOX_N-1:0]    irq_en,
   output logic                 ack_valid,
   output logic [MBOX_BITS-1:0] ack_slot
);

   logic [CNT_W-1:0] next_cnt, echo_cnt;
   logic             full, wrap_hold, pending, retire_go, accept;
   logic [MBOX_BITS-1:0] next_mb, echo_mb;
   logic [PRIO_BITS-1:0] next_prio;

   assign next_mb   = next_cnt[MBOX_BITS-1:0];
   assign next_prio = next_cnt[CNT_W-1:MBOX_BITS];
   assign echo_mb   = echo_cnt[MBOX_BITS-1:0];

   assign in_ready = !cmd_valid && !full && !wrap_hold && mb_ready[next_mb];
   assign accept   = in_valid && in_ready;

   tx_slot_counters #(
      .MBOX_BITS (MBOX_BITS),
      .PRIO_BITS (PRIO_BITS)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .retire    (retire_go),
      .next_cnt  (next_cnt),
      .echo_cnt  (echo_cnt),
      .full      (full),
      .wrap_hold (wrap_hold),
      .pending   (pending)
   );

   tx_load_fsm #(
      .MBOX_BITS (MBOX_BITS),
      .PRIO_BITS (PRIO_BITS),
      .ID_W      (ID_W),
      .DATA_W    (DATA_W),
      .DLC_W     (DLC_W)
   ) load_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .in_id    (in_id),
      .in_ext   (in_ext),
      .in_rtr   (in_rtr),
      .in_dlc   (in_dlc),
      .in_data  (in_data),
      .slot     (next_mb),
      .prio     (next_prio),
      .busy     (cmd_valid),
      .cmd_op   (cmd_op),
      .cmd_mbox (cmd_mbox),
      .cmd_data (cmd_data)
   );

   tx_retire_unit #(
      .MBOX_BITS (MBOX_BITS)
   ) ret_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_go     (accept),
      .load_mb     (next_mb),
      .echo_mb     (echo_mb),
      .pending     (pending),
      .done_pulse  (mb_done),
      .abort_pulse (mb_abort),
      .mb_ready    (mb_ready),
      .retire_go   (retire_go),
      .irq_en      (irq_en),
      .ack_valid   (ack_valid),
      .ack_slot    (ack_slot)
   );

   p_ready_needs_mbox_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> mb_ready[next_mb]);

   p_enables_cover_flight_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> irq_en == '0);

endmodule

// File: tb/tx_order_seq_tb_top.sv
module tx_order_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [28:0] in_id = '0;
   logic        in_ext = 1'b0;
   logic        in_rtr = 1'b0;
   logic [3:0]  in_dlc = '0;
   logic [63:0] in_data = '0;
   logic [3:0]  mb_ready = 4'hF;
   logic [3:0]  mb_done = '0;
   logic [3:0]  mb_abort = '0;
   logic        cmd_valid;
   logic [2:0]  cmd_op;
   logic [1:0]  cmd_mbox;
   logic [31:0] cmd_data;
   logic [3:0]  irq_en;
   logic        ack_valid;
   logic [1:0]  ack_slot;

   always #2 clk = ~clk;

   tx_order_seq dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_id(in_id), .in_ext(in_ext), .in_rtr(in_rtr), .in_dlc(in_dlc),
      .in_data(in_data), .mb_ready(mb_ready), .mb_done(mb_done),
      .mb_abort(mb_abort), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_mbox(cmd_mbox), .cmd_data(cmd_data), .irq_en(irq_en),
      .ack_valid(ack_valid), .ack_slot(ack_slot)
   );

   logic [36:0] cmdq[$];
   int          ackq[$];
   int          checks = 0;
   int          fails = 0;
   int          ack_seen = 0;
   int          exp_acks = 0;
   int          nxt_model = 0;
   int          cycles = 0;
   bit          finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] id_word(input logic [28:0] id, input bit ext);
      if (ext) return 32'h2000_0000 | {3'b0, id};
      return {21'b0, id[10:0]} << 18;
   endfunction

   task automatic send_frame(input logic [28:0] id, input bit ext, input bit rtr,
                             input logic [3:0] dlc, input logic [63:0] data,
                             input bit expect_ack, output int slot);
      int prio;
      @(negedge clk);
      in_id = id; in_ext = ext; in_rtr = rtr; in_dlc = dlc; in_data = data;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      slot = nxt_model % 4;
      prio = (nxt_model / 4) % 16;
      cmdq.push_back({3'd0, 2'(slot), 32'h0});
      cmdq.push_back({3'd1, 2'(slot), id_word(id, ext)});
      cmdq.push_back({3'd2, 2'(slot), 32'h100 | 32'(prio)});
      cmdq.push_back({3'd3, 2'(slot), data[31:0]});
      cmdq.push_back({3'd4, 2'(slot), data[63:32]});
      cmdq.push_back({3'd5, 2'(slot), 24'h0, 1'b1, 2'b00, rtr, dlc});
      if (expect_ack) begin
         ackq.push_back(slot);
         exp_acks++;
      end
      nxt_model = (nxt_model + 1) % 64;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (7) @(negedge clk);
   endtask

   task automatic pulse(input int m, input bit abort);
      @(negedge clk);
      if (abort) mb_abort[m] = 1'b1; else mb_done[m] = 1'b1;
      @(negedge clk);
      mb_abort = '0;
      mb_done  = '0;
   endtask

   // Scoreboard monitor: load bursts (R2, R3) and acknowledgements (R8)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (cmd_valid) begin
            if (cmdq.size() == 0) chk(1'b0, "R3 unexpected beat", {cmd_op, cmd_mbox, cmd_data}, 0);
            else begin
               logic [36:0] e;
               e = cmdq.pop_front();
               chk({cmd_op, cmd_mbox, cmd_data} == e, "R2 R3 load beat",
                   {cmd_op, cmd_mbox, cmd_data}, e);
            end
         end
         if (ack_valid) begin
            ack_seen++;
            if (ackq.size() == 0) chk(1'b0, "R8 unexpected ack", ack_slot, 0);
            else begin
               int e;
               e = ackq.pop_front();
               chk(ack_slot == 2'(e), "R8 ack slot order", ack_slot, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int s;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
      chk(cmd_valid == 1'b0 && ack_valid == 1'b0, "R1 outputs idle", {cmd_valid, ack_valid}, 0);
      chk(irq_en == 4'h0, "R1 irq_en", irq_en, 0);

      // R7 out-of-order completions retire in order
      send_frame(29'h123, 1'b0, 1'b0, 4'd8, 64'h0102030405060708, 1'b1, s);
      send_frame(29'h1ABCDEF0, 1'b1, 1'b0, 4'd2, 64'hCAFEBABE_DEADBEEF, 1'b1, s);
      send_frame(29'h7FF, 1'b0, 1'b1, 4'd0, 64'h0, 1'b1, s);
      pulse(2, 1'b0);
      pulse(1, 1'b0);
      repeat (6) @(negedge clk);
      chk(ack_seen == 0, "R7 younger waits", ack_seen, 0);
      chk(irq_en == 4'b0111, "R11 enables while loaded", irq_en, 4'b0111);
      pulse(0, 1'b0);
      repeat (6) @(negedge clk);
      chk(ack_seen == 3, "R7 drain in order", ack_seen, 3);
      chk(irq_en == 4'h0, "R11 enables cleared", irq_en, 0);

      // R4 full, R9 abort
      send_frame(29'h055, 1'b0, 1'b0, 4'd1, 64'h11, 1'b0, s);
      send_frame(29'h0F0F0F0F, 1'b1, 1'b0, 4'd4, 64'h2222_3333, 1'b1, s);
      send_frame(29'h3AA, 1'b0, 1'b0, 4'd8, 64'h4444_5555_6666_7777, 1'b1, s);
      send_frame(29'h1, 1'b1, 1'b1, 4'd3, 64'h8, 1'b1, s);
      chk(in_ready == 1'b0, "R4 four outstanding", in_ready, 0);
      chk(irq_en == 4'hF, "R11 all enabled", irq_en, 4'hF);
      pulse(3, 1'b1);
      repeat (6) @(negedge clk);
      chk(ack_seen == 3, "R9 abort no ack", ack_seen, 3);
      chk(in_ready == 1'b1, "R9 slot freed", in_ready, 1);
      chk(irq_en == 4'b0111, "R11 aborted slot disabled", irq_en, 4'b0111);
      pulse(0, 1'b0);
      pulse(1, 1'b0);
      pulse(2, 1'b0);
      repeat (6) @(negedge clk);
      chk(ack_seen == 6, "R8 acks after abort", ack_seen, 6);

      // R5 next mailbox not ready (next slot is 3)
      @(negedge clk);
      mb_ready[3] = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b0, "R5 next not ready", in_ready, 0);
      mb_ready[3] = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R5 ready again", in_ready, 1);

      // R12 stray event ignored and not remembered
      pulse(3, 1'b0);
      repeat (6) @(negedge clk);
      chk(ack_seen == 6, "R12 stray no ack", ack_seen, 6);
      chk(irq_en == 4'h0, "R12 stray no enable", irq_en, 0);
      send_frame(29'h2C3, 1'b0, 1'b0, 4'd5, 64'h99AA, 1'b1, s);
      repeat (8) @(negedge clk);
      chk(ack_seen == 6, "R12 stray not remembered", ack_seen, 6);
      pulse(3, 1'b0);
      repeat (6) @(negedge clk);
      chk(ack_seen == 7, "R8 single ack", ack_seen, 7);

      // R10 ready low at retirement
      send_frame(29'h044, 1'b0, 1'b0, 4'd6, 64'h1234, 1'b0, s);
      @(negedge clk);
      mb_ready[0] = 1'b0;
      pulse(0, 1'b0);
      repeat (6) @(negedge clk);
      chk(ack_seen == 7, "R10 no ack when not ready", ack_seen, 7);
      chk(irq_en == 4'h0, "R10 retired anyway", irq_en, 0);
      mb_ready[0] = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R10 input open", in_ready, 1);

      // R6 wrap: run up to frame 63, hold the last one
      while (nxt_model != 63) begin
         send_frame(29'(nxt_model * 7), nxt_model[0], 1'b0, 4'(nxt_model),
                    {32'(nxt_model), 32'hA5A5_0000 | 32'(nxt_model)}, 1'b1, s);
         pulse(s, 1'b0);
         repeat (3) @(negedge clk);
      end
      send_frame(29'h3F3F, 1'b1, 1'b0, 4'd7, 64'hFEED_F00D_0BAD_BEEF, 1'b1, s);
      chk(s == 3, "R2 last slot", s, 3);
      chk(in_ready == 1'b0, "R6 hold at wrap", in_ready, 0);
      repeat (10) @(negedge clk);
      chk(in_ready == 1'b0, "R6 still held", in_ready, 0);
      pulse(3, 1'b0);
      repeat (6) @(negedge clk);
      chk(in_ready == 1'b1, "R6 resumes after drain", in_ready, 1);
      send_frame(29'h0AB, 1'b0, 1'b1, 4'd0, 64'h5, 1'b1, s);
      chk(s == 0, "R2 restart at slot 0", s, 0);
      pulse(0, 1'b0);
      repeat (6) @(negedge clk);

      chk(ack_seen == exp_acks, "R8 ack total", ack_seen, exp_acks);
      chk(ackq.size() == 0 && cmdq.size() == 0, "R3 R8 queues drained",
          ackq.size() + cmdq.size(), 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule